// File: doc/BRIEF.md
# Masked Vector Register Execution Unit

This block is an integer vector datapath built around a file of eight vector registers, each with 64 elements of 64 bits. One instruction is accepted at a time through a valid/ready handshake. An instruction either combines two vector registers element by element, or combines a vector register with a 64-bit scalar. The supported operations are add, multiply (low half kept) and two compares. A compare writes one bit per element into a 64-bit vector mask.

A programmable vector length sets how many leading elements an instruction touches. An arithmetic instruction flagged as conditional writes only those elements whose mask bit is set. Elements are handled one per clock. The unit holds busy while it walks the elements and pulses done once the walk ends. A side port writes single elements while the unit is idle. A combinational read port returns any element, and the mask and vector length are visible as outputs.

Top module: `vmx_exec`

## Requirements
- R1: After reset, vlen reads 64, mask reads 0, busy and done are low and in_ready is high.
- R2: Opcode 4 (set length) loads vlen with the scalar, capped at 64. It never raises busy.
- R3: Opcode 0 (add) and opcode 1 (multiply, low 64 bits of the product) write dst[i] = src1[i] op B for each i below vlen. B is the scalar when in_use_scalar is 1, and src2[i] otherwise.
- R4: Destination elements at index vlen and above keep their previous contents.
- R5: When in_masked is 1, an add or multiply writes only the elements whose mask bit is 1. Every other element keeps its old value.
- R6: Opcode 2 (equal) and opcode 3 (unsigned less-than) set mask bit i to the compare result of src1[i] against B for each i below vlen. Mask bits at vlen and above become 0. The in_masked flag has no effect on a compare, and only compares change the mask.
- R7: An add, multiply or compare with vlen N > 0 holds busy for exactly N cycles, starting in the cycle after acceptance. done is then high for one cycle. Any other accepted instruction, and any element instruction with vlen 0, pulses done in the cycle after acceptance and never raises busy.
- R8: in_ready equals not busy. An in_valid presented while busy is ignored.
- R9: When ld_en is high and the unit is idle, ld_data is written to element ld_idx of register ld_reg at the clock edge. A load presented while busy is ignored.
- R10: Opcodes 5, 6 and 7 change no register, mask or length. They only pulse done.
- R11: rd_data returns element rd_idx of register rd_reg combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken (unit idle) |
| in_op | input | 3 | Opcode: 0 add, 1 mul, 2 equal, 3 less-than, 4 set length |
| in_masked | input | 1 | Conditional write under the mask |
| in_use_scalar | input | 1 | Second operand is in_scalar |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_scalar | input | 64 | Scalar operand or new length |
| busy | output | 1 | Element walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load value |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 64 | Read value |
| mask | output | 64 | Vector mask |
| vlen | output | 7 | Vector length |

## Verification
Take an element instruction accepted at a clock edge with length N. Its elements are written on the N following edges, busy is visible for N cycles, and done appears in cycle N+1. A set-length, an unused opcode or a zero-length instruction shows done in cycle 1, and the new vlen is visible in that same cycle. The bench drives and samples on the falling edge. It counts falling edges from acceptance to done and compares that count with the figures above. It also counts busy cycles along the way and confirms that done has dropped one cycle later. Register contents, mask and length are read only after done, when nothing is moving. Loads and reads on the side ports take effect on the next edge and combinationally, respectively.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  typedef enum logic [2:0] {
    VOP_ADD    = 3'd0,
    VOP_MUL    = 3'd1,
    VOP_CEQ    = 3'd2,
    VOP_CLT    = 3'd3,
    VOP_SETLEN = 3'd4
  } vop_e;

  function automatic logic is_arith(input logic [2:0] op);
    return (op == VOP_ADD) || (op == VOP_MUL);
  endfunction

  function automatic logic is_cmp(input logic [2:0] op);
    return (op == VOP_CEQ) || (op == VOP_CLT);
  endfunction

  function automatic logic is_elem(input logic [2:0] op);
    return is_arith(op) || is_cmp(op);
  endfunction
endpackage

// File: rtl/vmx_regfile.sv
module vmx_regfile #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int AW   = $clog2(NREG) + $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [EW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [EW-1:0] rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [EW-1:0] rc_data
);
  localparam int DEPTH = NREG * NELEM;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];
endmodule

// File: rtl/vmx_lane.sv
module vmx_lane
  import vmx_pkg::*;
#(
  parameter int EW = 64
) (
  input  logic [2:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          flag
);
  always_comb begin
    if (op == VOP_MUL) res = a * b;
    else               res = a + b;
    if (op == VOP_CLT) flag = (a < b);
    else               flag = (a == b);
  end
endmodule

// File: rtl/vmx_ctrl.sv
module vmx_ctrl
  import vmx_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM),
  localparam int LW   = $clog2(NELEM + 1),
  localparam int AW   = RW + IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_masked,
  input  logic             in_use_scalar,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src1,
  input  logic [RW-1:0]    in_src2,
  input  logic [EW-1:0]    in_scalar,
  input  logic             ld_en,
  input  logic [RW-1:0]    ld_reg,
  input  logic [IW-1:0]    ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic [EW-1:0]    lane_res,
  input  logic             lane_flag,
  output logic [2:0]       op_o,
  output logic             use_scalar_o,
  output logic [EW-1:0]    scalar_o,
  output logic [AW-1:0]    src1_addr,
  output logic [AW-1:0]    src2_addr,
  output logic             rf_we,
  output logic [AW-1:0]    rf_waddr,
  output logic [EW-1:0]    rf_wdata,
  output logic             busy,
  output logic             done,
  output logic [LW-1:0]    vlen,
  output logic [NELEM-1:0] mask
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [LW-1:0]    vl_q, vl_d;
  logic [NELEM-1:0] mask_q, mask_d;

  logic [2:0]       op_q;
  logic             msk_q, scl_q;
  logic [RW-1:0]    dst_q, s1_q, s2_q;
  logic [EW-1:0]    k_q;

  logic accept, last, elem_wr;

  assign accept   = in_valid && !busy_q;
  assign in_ready = !busy_q;
  assign last     = (LW'(idx_q) == (vl_q - LW'(1)));

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    vl_d   = vl_q;
    mask_d = mask_q;
    if (accept) begin
      if (is_elem(in_op) && (vl_q != '0)) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end else begin
        done_d = 1'b1;
      end
      if (in_op == VOP_SETLEN)
        vl_d = (in_scalar > EW'(NELEM)) ? LW'(NELEM) : in_scalar[LW-1:0];
      if (is_cmp(in_op)) mask_d = '0;
    end else if (busy_q) begin
      if (is_cmp(op_q)) mask_d[idx_q] = lane_flag;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  assign elem_wr = busy_q && is_arith(op_q) && (!msk_q || mask_q[idx_q]);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = {ld_reg, ld_idx};
    rf_wdata = ld_data;
    if (busy_q) begin
      rf_we    = elem_wr;
      rf_waddr = {dst_q, idx_q};
      rf_wdata = lane_res;
    end else if (ld_en) begin
      rf_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= LW'(NELEM);
      mask_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      vl_q   <= vl_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q  <= in_op;
      msk_q <= in_masked;
      scl_q <= in_use_scalar;
      dst_q <= in_dst;
      s1_q  <= in_src1;
      s2_q  <= in_src2;
      k_q   <= in_scalar;
    end
  end

  assign op_o         = op_q;
  assign use_scalar_o = scl_q;
  assign scalar_o     = k_q;
  assign src1_addr    = {s1_q, idx_q};
  assign src2_addr    = {s2_q, idx_q};
  assign busy         = busy_q;
  assign done         = done_q;
  assign vlen         = vl_q;
  assign mask         = mask_q;
endmodule

// File: rtl/vmx_exec.sv
module vmx_exec #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM),
  localparam int LW   = $clog2(NELEM + 1),
  localparam int AW   = RW + IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_masked,
  input  logic             in_use_scalar,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src1,
  input  logic [RW-1:0]    in_src2,
  input  logic [EW-1:0]    in_scalar,
  output logic             busy,
  output logic             done,
  input  logic             ld_en,
  input  logic [RW-1:0]    ld_reg,
  input  logic [IW-1:0]    ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic [RW-1:0]    rd_reg,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_data,
  output logic [NELEM-1:0] mask,
  output logic [LW-1:0]    vlen
);
  logic [1:0]    rs_q;
  logic          core_rst_n;
  logic [2:0]    op_w;
  logic          scl_w, rf_we, lane_flag;
  logic [EW-1:0] k_w, ra_data, rb_data, opnd_b, lane_res, rf_wdata;
  logic [AW-1:0] s1_addr, s2_addr, rf_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  vmx_ctrl #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_masked(in_masked), .in_use_scalar(in_use_scalar),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_scalar(in_scalar),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .lane_res(lane_res), .lane_flag(lane_flag),
    .op_o(op_w), .use_scalar_o(scl_w), .scalar_o(k_w),
    .src1_addr(s1_addr), .src2_addr(s2_addr),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .vlen(vlen), .mask(mask)
  );

  vmx_regfile #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(s1_addr), .ra_data(ra_data),
    .rb_addr(s2_addr), .rb_data(rb_data),
    .rc_addr({rd_reg, rd_idx}), .rc_data(rd_data)
  );

  assign opnd_b = scl_w ? k_w : rb_data;

  vmx_lane #(.EW(EW)) u_lane (
    .op(op_w), .a(ra_data), .b(opnd_b), .res(lane_res), .flag(lane_flag)
  );
endmodule

// File: rtl/vmx_checker.sv
module vmx_checker
  import vmx_pkg::*;
#(
  parameter int NELEM = 64,
  localparam int LW   = $clog2(NELEM + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             busy,
  input logic             done,
  input logic [NELEM-1:0] mask,
  input logic [LW-1:0]    vlen
);
  logic          acc;
  logic          cmp_q;
  logic [LW-1:0] bcnt_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= 1'b0;
      bcnt_q <= '0;
    end else begin
      if (acc) cmp_q <= is_cmp(in_op);
      bcnt_q <= busy ? bcnt_q + LW'(1) : '0;
    end
  end

  a_r7_accept_responds: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (busy || done));

  a_r7_busy_within_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt_q < vlen));

  a_r7_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r2_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    vlen <= LW'(NELEM));

  a_r2_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(vlen));

  a_r6_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmp_q) |-> ((mask >> vlen) == '0));

  a_r6_mask_only_by_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(acc && is_cmp(in_op))) |=> $stable(mask));

  a_r8_start_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc));
endmodule

bind vmx_exec vmx_checker #(.NELEM(NELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .busy(busy), .done(done), .mask(mask), .vlen(vlen)
);

// File: tb/sim_vmx_exec.sv
`timescale 1ns/1ps
module sim_vmx_exec;
  typedef struct packed {
    logic [2:0]  op;
    logic        m;
    logic        s;
    logic [2:0]  d;
    logic [2:0]  a;
    logic [2:0]  b;
    logic [63:0] k;
  } ent_t;

  localparam int NT = 14;
  localparam ent_t TBL [NT] = '{
    '{3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 64'd20},
    '{3'd0, 1'b0, 1'b0, 3'd3, 3'd0, 3'd1, 64'd0},
    '{3'd1, 1'b0, 1'b1, 3'd4, 3'd1, 3'd0, 64'd3},
    '{3'd2, 1'b1, 1'b0, 3'd0, 3'd1, 3'd2, 64'd0},
    '{3'd0, 1'b1, 1'b0, 3'd5, 3'd0, 3'd0, 64'd0},
    '{3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 64'd70},
    '{3'd3, 1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 64'd5},
    '{3'd1, 1'b1, 1'b0, 3'd6, 3'd6, 3'd1, 64'd0},
    '{3'd0, 1'b0, 1'b1, 3'd7, 3'd7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 64'd0},
    '{3'd0, 1'b0, 1'b0, 3'd3, 3'd1, 3'd1, 64'd0},
    '{3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 64'd0},
    '{3'd5, 1'b0, 1'b0, 3'd4, 3'd0, 3'd1, 64'd9},
    '{3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 64'd64}
  };

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_masked, in_use_scalar;
  logic [2:0]  in_op, in_dst, in_src1, in_src2;
  logic [63:0] in_scalar;
  logic        busy, done;
  logic        ld_en;
  logic [2:0]  ld_reg, rd_reg;
  logic [5:0]  ld_idx, rd_idx;
  logic [63:0] ld_data, rd_data, mask;
  logic [6:0]  vlen;

  logic [63:0] sh [8][64];
  logic [63:0] mmask;
  int          mvl;
  int          n_chk, n_fail;

  vmx_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_masked(in_masked), .in_use_scalar(in_use_scalar),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_scalar(in_scalar),
    .busy(busy), .done(done), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
    .mask(mask), .vlen(vlen)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic m);
    if (op > 3'd4) return "R10";
    if (op == 3'd4) return "R2";
    if (op == 3'd2 || op == 3'd3) return "R6";
    if (m) return "R5";
    return "R3";
  endfunction

  function automatic bit el_op(input logic [2:0] op);
    return op <= 3'd3;
  endfunction

  task automatic model_exec(input ent_t e);
    logic [63:0] bv, nm;
    if (e.op == 3'd4) begin
      mvl = (e.k > 64) ? 64 : int'(e.k);
    end else if (e.op == 3'd0 || e.op == 3'd1) begin
      for (int i = 0; i < mvl; i++) begin
        bv = e.s ? e.k : sh[e.b][i];
        if (!e.m || mmask[i])
          sh[e.d][i] = (e.op == 3'd1) ? sh[e.a][i] * bv : sh[e.a][i] + bv;
      end
    end else if (e.op == 3'd2 || e.op == 3'd3) begin
      nm = '0;
      for (int i = 0; i < mvl; i++) begin
        bv = e.s ? e.k : sh[e.b][i];
        nm[i] = (e.op == 3'd3) ? (sh[e.a][i] < bv) : (sh[e.a][i] == bv);
      end
      mmask = nm;
    end
  endtask

  // Head (below len) under tag, tail under R4
  task automatic check_vec(input int r, input int len, input string tag);
    bit hok, tok;
    logic [63:0] ha, he, ta, te;
    hok = 1'b1; tok = 1'b1;
    ha = '0; he = '0; ta = '0; te = '0;
    for (int i = 0; i < 64; i++) begin
      rd_reg = 3'(r); rd_idx = 6'(i);
      #0.01;
      if (rd_data !== sh[r][i]) begin
        if (i < len && hok) begin hok = 1'b0; ha = rd_data; he = sh[r][i]; end
        if (i >= len && tok) begin tok = 1'b0; ta = rd_data; te = sh[r][i]; end
      end
    end
    chk(hok, tag, ha, he);
    chk(tok, "R4 tail", ta, te);
  endtask

  task automatic run_op(input ent_t e);
    int lat, bc, exp_lat, vl0;
    string tg;
    vl0 = mvl;
    tg = tag_of(e.op, e.m);
    exp_lat = (el_op(e.op) && mvl != 0) ? mvl + 1 : 1;
    @(negedge clk);
    in_valid = 1'b1; in_op = e.op; in_masked = e.m; in_use_scalar = e.s;
    in_dst = e.d; in_src1 = e.a; in_src2 = e.b; in_scalar = e.k;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1; bc = busy ? 1 : 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (busy) bc++;
    end
    chk(lat == exp_lat, "R7 done latency", 64'(lat), 64'(exp_lat));
    chk(bc == exp_lat - 1, "R7 busy cycles", 64'(bc), 64'(exp_lat - 1));
    model_exec(e);
    chk(vlen == 7'(mvl), tg, 64'(vlen), 64'(mvl));
    @(negedge clk);
    chk(!done, "R7 done pulse width", 64'(done), 64'd0);
    chk(mask === mmask, tg, mask, mmask);
    check_vec(e.d, vl0, tg);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_masked = 1'b0; in_use_scalar = 1'b0;
    in_dst = '0; in_src1 = '0; in_src2 = '0; in_scalar = '0;
    ld_en = 1'b0; ld_reg = '0; ld_idx = '0; ld_data = '0; rd_reg = '0; rd_idx = '0;
    mvl = 64; mmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(vlen == 7'd64, "R1 vlen", 64'(vlen), 64'd64);
    chk(mask == '0, "R1 mask", mask, 64'd0);
    chk(!busy && !done, "R1 busy/done", {62'd0, busy, done}, 64'd0);
    chk(in_ready, "R1 ready", 64'(in_ready), 64'd1);

    // Fill registers through the load port (R9)
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 64; i++) begin
        logic [63:0] v1;
        v1 = 64'(i * 3 + 7);
        if (r == 0)      sh[r][i] = 64'(i);
        else if (r == 1) sh[r][i] = v1;
        else if (r == 2) sh[r][i] = (i % 2 == 0) ? v1 : v1 + 64'd1;
        else             sh[r][i] = 64'hA000_0000_0000_0000 + 64'(r * 256 + i);
        @(negedge clk);
        ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = sh[r][i];
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
    check_vec(2, 64, "R9 load");

    // R11 combinational read
    rd_reg = 3'd1; rd_idx = 6'd5;
    #0.01;
    chk(rd_data == 64'd22, "R11 read", rd_data, 64'd22);

    for (int t = 0; t < NT; t++) run_op(TBL[t]);

    // R8 / R9: offers while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_masked = 1'b0; in_use_scalar = 1'b0;
    in_dst = 3'd2; in_src1 = 3'd2; in_src2 = 3'd1; in_scalar = '0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R8 ready low while busy", 64'(in_ready), 64'd0);
    in_valid = 1'b1; in_op = 3'd4; in_scalar = 64'd3;
    ld_en = 1'b1; ld_reg = 3'd7; ld_idx = 6'd0; ld_data = 64'hDEAD;
    @(negedge clk);
    in_valid = 1'b0; ld_en = 1'b0;
    begin
      int w;
      w = 0;
      while (!done && w < 200) begin @(negedge clk); w++; end
    end
    model_exec('{3'd0, 1'b0, 1'b0, 3'd2, 3'd2, 3'd1, 64'd0});
    chk(vlen == 7'd64, "R8 offer while busy ignored", 64'(vlen), 64'd64);
    repeat (3) begin
      @(negedge clk);
      chk(!done, "R8 no extra completion", 64'(done), 64'd0);
    end
    rd_reg = 3'd7; rd_idx = 6'd0;
    #0.01;
    chk(rd_data == sh[7][0], "R9 load while busy ignored", rd_data, sh[7][0]);
    check_vec(2, 64, "R3 full length");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule